// File: doc/BRIEF.md
# Dual-Channel Timer Register Bank

This block puts two down-counting timer channels behind one APB slave port that decodes a 4 KB window. Each channel has its own 32-byte slot holding a reload value, the live count, a control byte, an interrupt acknowledge location and raw and masked interrupt flags. The channels count in 16-bit or 32-bit width, in free-running, periodic or single-shot fashion, at the bus clock divided by 1, 16 or 256. Each channel raises a sticky flag when its count steps from one to zero.

Three interrupt lines leave the block: one per channel and one that is the OR of the two. A small test area near the top of the window lets software take over both per-channel lines from a register, so that interrupt wiring can be checked without waiting for a timer. The last twelve words of the window hold fixed identification bytes. The bus has no wait states and never signals an error.

Top module: `dtb_bank`

## Requirements
- R1: Channel 0 occupies byte offsets 0x00-0x1C and channel 1 offsets 0x20-0x3C; inside a slot 0x00 is the reload value (a write also copies it into the count), 0x04 the count, 0x08 the control byte, 0x0C acknowledge, 0x10 raw flag, 0x14 masked flag, 0x18 the background reload; both 0x00 and 0x18 read the reload value. Control bits: 7 run, 6 periodic, 5 interrupt enable, 3:2 divider select, 1 width (1 = 32 bits), 0 single-shot; bit 4 and bits above 7 read as zero.
- R2: A write to offset 0x18 changes the reload value only and leaves the count untouched.
- R3: While running, the count drops by one per divider tick; a tick that takes it from one to zero sets the raw flag; a tick at zero loads the reload value (periodic), all ones of the active width (free-running), or keeps zero (single-shot).
- R4: In 16-bit width only bits 15:0 of the count change on ticks; bits 31:16 hold their value.
- R5: Divider select 0 ticks every clock, 1 every 16 clocks, 2 and 3 every 256 clocks; the divider restarts on any reload write (0x00) or control write.
- R6: Offset 0x10 returns the raw flag in bit 0 and 0x14 returns raw AND interrupt enable in bit 0; any write to 0x0C clears the raw flag, except that a flag set by a tick in the same cycle stays set.
- R7: With test mode off, each interrupt line equals its channel's raw flag AND interrupt enable, one clock after that state.
- R8: Offset 0xF00 bit 0 enables test mode and reads back; offset 0xF04 is write-only (reads zero) and, in test mode, its bit 0 drives the channel 0 line and bit 1 the channel 1 line, one clock later.
- R9: The combined interrupt line equals the OR of the two per-channel lines in every cycle, in both modes.
- R10: Words at 0xFD0 through 0xFFC read, in address order, 0x04, 0x00, 0x00, 0x00, 0x23, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1; writes there are ignored.
- R11: Reads of any other offset return zero and writes to them change nothing.
- R12: After reset each channel has control 0x20, count 0xFFFFFFFF, reload 0 and a clear raw flag; both test registers are zero and all interrupt lines are low.
- R13: PREADY is always high and PSLVERR always low; read data is captured at the setup-phase clock edge and held through the access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase marker |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte address within the window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| irq_ch | output | 2 | Per-channel interrupt lines |
| irq_any | output | 1 | OR of the per-channel lines |

## Verification
The counters are driven with a 32-bit periodic pattern, a 16-bit single-shot run that parks at zero and is then switched to free-running so that its wrap to 0xFFFF shows whether the upper half is preserved, and with divider settings of 16 and 256, where a read mid-interval separates a correct divider from one that ticks every clock. Masking is tried with the interrupt enable both set and clear, so that raw and masked flags must differ. Test mode is entered with both line patterns while a real flag is pending, which tells an override apart from an OR with the timer flag. Unmapped, aliased and identification addresses are written and read back to show that no decode leaks into a channel.

// File: rtl/dtb_pkg.sv
package dtb_pkg;

    localparam int REG_W  = 32;
    localparam int HALF_W = REG_W / 2;
    localparam int PS_W   = 8;

    // Control byte; field order is the software-visible bit layout.
    typedef struct packed {
        logic       run;
        logic       reload_mode;
        logic       irq_en;
        logic       spare;
        logic [1:0] div_sel;
        logic       wide;
        logic       single;
    } tmr_ctrl_t;

    localparam logic [7:0] CTRL_KEEP = 8'hEF;
    localparam logic [7:0] CTRL_RST  = 8'h20;

    // Word slots inside one channel's 32-byte region.
    localparam logic [2:0] SLOT_RELOAD   = 3'd0;
    localparam logic [2:0] SLOT_COUNT    = 3'd1;
    localparam logic [2:0] SLOT_CTRL     = 3'd2;
    localparam logic [2:0] SLOT_ACK      = 3'd3;
    localparam logic [2:0] SLOT_RAW      = 3'd4;
    localparam logic [2:0] SLOT_MASKED   = 3'd5;
    localparam logic [2:0] SLOT_BGRELOAD = 3'd6;

    // Word addresses (byte address >> 2) for a 12-bit window.
    localparam logic [9:0] W_TEST_EN  = 10'h3C0;
    localparam logic [9:0] W_TEST_OUT = 10'h3C1;
    localparam logic [9:0] W_ID_FIRST = 10'h3F4;

    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        logic [7:0] b;
        case (idx)
            4'd0:    b = 8'h04;
            4'd4:    b = 8'h23;
            4'd5:    b = 8'hB8;
            4'd6:    b = 8'h1B;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

    // Terminal count of the divider for each select code.
    function automatic logic [PS_W-1:0] div_limit(input logic [1:0] sel);
        logic [PS_W-1:0] l;
        case (sel)
            2'd0:    l = '0;
            2'd1:    l = PS_W'(15);
            default: l = PS_W'(255);
        endcase
        return l;
    endfunction

endpackage

// File: rtl/dtb_prescale.sv
module dtb_prescale
    import dtb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       clr,
    input  logic [1:0] sel,
    output logic       tick
);

    logic [PS_W-1:0] cnt_d, cnt_q;
    logic [PS_W-1:0] lim;

    always_comb begin
        lim  = div_limit(sel);
        tick = en && (cnt_q >= lim);
        if (!en || clr || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // A divided tick is never followed by another unless the divider is 1.
    AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != 2'd0) |=> (!tick || sel == 2'd0)); // R5

endmodule

// File: rtl/dtb_channel.sv
module dtb_channel
    import dtb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_reload,
    input  logic             wr_bgreload,
    input  logic             wr_ctrl,
    input  logic             wr_ack,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] reload_o,
    output logic [REG_W-1:0] count_o,
    output tmr_ctrl_t        ctrl_o,
    output logic             raw_o
);

    typedef struct packed {
        logic [REG_W-1:0] reload;
        logic [REG_W-1:0] count;
        tmr_ctrl_t        ctrl;
        logic             raw;
    } ch_state_t;

    ch_state_t        st_d, st_q;
    logic             tick;
    logic             hit;
    logic [REG_W-1:0] mask;
    logic [REG_W-1:0] view;
    logic [REG_W-1:0] stepped;

    dtb_prescale u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (st_q.ctrl.run),
        .clr   (wr_reload | wr_ctrl),
        .sel   (st_q.ctrl.div_sel),
        .tick  (tick)
    );

    always_comb begin
        st_d    = st_q;
        mask    = st_q.ctrl.wide ? {REG_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
        view    = st_q.count & mask;
        hit     = 1'b0;
        stepped = view;

        if (tick) begin
            if (view == REG_W'(1)) begin
                stepped = '0;
                hit     = 1'b1;
            end else if (view == '0) begin
                if (st_q.ctrl.single) begin
                    stepped = '0;
                end else if (st_q.ctrl.reload_mode) begin
                    stepped = st_q.reload & mask;
                end else begin
                    stepped = mask;
                end
            end else begin
                stepped = view - 1'b1;
            end
        end

        st_d.count = (st_q.count & ~mask) | (stepped & mask);

        if (hit) begin
            st_d.raw = 1'b1;
        end else if (wr_ack) begin
            st_d.raw = 1'b0;
        end

        if (wr_reload) begin
            st_d.reload = wdata;
            st_d.count  = wdata;
        end
        if (wr_bgreload) begin
            st_d.reload = wdata;
        end
        if (wr_ctrl) begin
            st_d.ctrl = tmr_ctrl_t'(wdata[7:0] & CTRL_KEEP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.reload <= '0;
            st_q.count  <= '1;
            st_q.ctrl   <= tmr_ctrl_t'(CTRL_RST);
            st_q.raw    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reload_o = st_q.reload;
    assign count_o  = st_q.count;
    assign ctrl_o   = st_q.ctrl;
    assign raw_o    = st_q.raw;

    AST_SINGLE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.run && st_q.ctrl.single && view == '0 && !wr_reload && !wr_ctrl)
        |=> $stable(st_q.count)); // R3

    AST_HIT_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && view == REG_W'(1)) |=> st_q.raw); // R3

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.wide && !wr_reload) |=> $stable(st_q.count[REG_W-1:HALF_W])); // R4

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && !(tick && view == REG_W'(1))) |=> !st_q.raw); // R6

endmodule

// File: rtl/dtb_bank.sv
module dtb_bank
    import dtb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [REG_W-1:0]  pwdata,
    output logic [REG_W-1:0]  prdata,
    output logic              pready,
    output logic              pslverr,
    output logic [NUM_CH-1:0] irq_ch,
    output logic              irq_any
);

    localparam int WORD_W   = ADDR_W - 2;
    localparam int CH_IDX_W = ADDR_W - 5;

    typedef struct packed {
        logic              test_en;
        logic [NUM_CH-1:0] test_out;
        logic [NUM_CH-1:0] irq;
        logic              irq_any;
        logic [REG_W-1:0]  rdata;
    } bank_state_t;

    bank_state_t st_d, st_q;

    logic [WORD_W-1:0]   word;
    logic [CH_IDX_W-1:0] ch_sel;
    logic [2:0]          slot;
    logic                wr_go;
    logic                rd_setup;
    logic                ch_hit;
    logic [REG_W-1:0]    rd_val;
    logic [NUM_CH-1:0]   irq_src;

    logic [REG_W-1:0] ch_reload [NUM_CH];
    logic [REG_W-1:0] ch_count  [NUM_CH];
    tmr_ctrl_t        ch_ctrl   [NUM_CH];
    logic             ch_raw    [NUM_CH];

    logic unused_lsb;
    assign unused_lsb = &{1'b0, paddr[1:0]};

    assign word     = paddr[ADDR_W-1:2];
    assign ch_sel   = paddr[ADDR_W-1:5];
    assign slot     = paddr[4:2];
    assign wr_go    = psel && penable && pwrite;
    assign rd_setup = psel && !penable && !pwrite;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic sel_g;
        assign sel_g = wr_go && (ch_sel == CH_IDX_W'(g));

        dtb_channel u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_reload   (sel_g && slot == SLOT_RELOAD),
            .wr_bgreload (sel_g && slot == SLOT_BGRELOAD),
            .wr_ctrl     (sel_g && slot == SLOT_CTRL),
            .wr_ack      (sel_g && slot == SLOT_ACK),
            .wdata       (pwdata),
            .reload_o    (ch_reload[g]),
            .count_o     (ch_count[g]),
            .ctrl_o      (ch_ctrl[g]),
            .raw_o       (ch_raw[g])
        );

        AST_NORMAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
            !st_q.test_en |=> (irq_ch[g] == $past(ch_raw[g] && ch_ctrl[g].irq_en))); // R7
    end

    always_comb begin
        st_d   = st_q;
        rd_val = '0;
        ch_hit = 1'b0;

        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_sel == CH_IDX_W'(i)) begin
                ch_hit = 1'b1;
                case (slot)
                    SLOT_RELOAD, SLOT_BGRELOAD: rd_val = ch_reload[i];
                    SLOT_COUNT:  rd_val = ch_count[i];
                    SLOT_CTRL:   rd_val = {{(REG_W-8){1'b0}}, ch_ctrl[i]};
                    SLOT_RAW:    rd_val = {{(REG_W-1){1'b0}}, ch_raw[i]};
                    SLOT_MASKED: rd_val = {{(REG_W-1){1'b0}}, ch_raw[i] && ch_ctrl[i].irq_en};
                    default:     rd_val = '0;
                endcase
            end
        end
        if (!ch_hit) begin
            if (word == W_TEST_EN) begin
                rd_val = {{(REG_W-1){1'b0}}, st_q.test_en};
            end else if (word >= W_ID_FIRST) begin
                rd_val = {{(REG_W-8){1'b0}}, id_byte(4'(word - W_ID_FIRST))};
            end
        end

        for (int i = 0; i < NUM_CH; i++) begin
            irq_src[i] = st_q.test_en ? st_q.test_out[i] : (ch_raw[i] && ch_ctrl[i].irq_en);
        end
        st_d.irq     = irq_src;
        st_d.irq_any = |irq_src;

        if (wr_go && word == W_TEST_EN) begin
            st_d.test_en = pwdata[0];
        end
        if (wr_go && word == W_TEST_OUT) begin
            st_d.test_out = pwdata[NUM_CH-1:0];
        end
        if (rd_setup) begin
            st_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prdata  = st_q.rdata;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign irq_ch  = st_q.irq;
    assign irq_any = st_q.irq_any;

    AST_ANY_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any == (|irq_ch)); // R9

    AST_TEST_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.test_en |=> (irq_ch == $past(st_q.test_out))); // R8

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_setup |=> $stable(prdata)); // R13

endmodule

// File: tb/dtb_bank_test.sv
module dtb_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic [1:0]  irq_ch;
    logic        irq_any;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    dtb_bank uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .irq_ch(irq_ch), .irq_any(irq_any)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_load [2];
    logic [31:0] m_val  [2];
    logic [7:0]  m_ctrl [2];
    logic        m_raw  [2];
    int          m_pc   [2];
    logic        m_ten;
    logic [1:0]  m_tout;
    logic [1:0]  m_irq;
    logic        m_any;
    logic [31:0] m_rd;
    logic [7:0]  id_tab [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h23, 8'hB8,
                                 8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int c;
        c = int'(a[11:5]);
        if (c < 2) begin
            case (a[4:2])
                3'd0, 3'd6: return m_load[c];
                3'd1:       return m_val[c];
                3'd2:       return {24'h0, m_ctrl[c]};
                3'd4:       return {31'h0, m_raw[c]};
                3'd5:       return {31'h0, m_raw[c] & m_ctrl[c][5]};
                default:    return 32'h0;
            endcase
        end
        if (a[11:2] == 10'h3C0) return {31'h0, m_ten};
        if (a >= 12'hFD0) return {24'h0, id_tab[(a - 12'hFD0) >> 2]};
        return 32'h0;
    endfunction

    logic [1:0] nx_irq;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_load[c] = 32'h0; m_val[c] = 32'hFFFF_FFFF;
                m_ctrl[c] = 8'h20; m_raw[c] = 1'b0; m_pc[c] = 0;
            end
            m_ten = 1'b0; m_tout = 2'b00; m_irq = 2'b00; m_any = 1'b0; m_rd = 32'h0;
        end else begin
            for (int c = 0; c < 2; c++)
                nx_irq[c] = m_ten ? m_tout[c] : (m_raw[c] & m_ctrl[c][5]);
            if (psel && !penable && !pwrite) m_rd = model_read(paddr);
            for (int c = 0; c < 2; c++) begin
                automatic bit wr  = psel && penable && pwrite && (int'(paddr[11:5]) == c);
                automatic bit wl  = wr && paddr[4:2] == 3'd0;
                automatic bit wb  = wr && paddr[4:2] == 3'd6;
                automatic bit wc  = wr && paddr[4:2] == 3'd2;
                automatic bit wa  = wr && paddr[4:2] == 3'd3;
                automatic bit en  = m_ctrl[c][7];
                automatic int lim = (m_ctrl[c][3:2] == 2'd0) ? 0 : (m_ctrl[c][3:2] == 2'd1) ? 15 : 255;
                automatic bit tk  = en && (m_pc[c] >= lim);
                automatic logic [31:0] msk = m_ctrl[c][1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
                automatic logic [31:0] v = m_val[c] & msk;
                automatic logic [31:0] nv = v;
                automatic bit set = 1'b0;
                m_pc[c] = (!en || wl || wc || tk) ? 0 : m_pc[c] + 1;
                if (tk) begin
                    if (v == 32'd1) begin nv = 0; set = 1'b1; end
                    else if (v == 32'd0) nv = m_ctrl[c][0] ? 32'd0 : (m_ctrl[c][6] ? (m_load[c] & msk) : msk);
                    else nv = v - 1;
                end
                m_val[c] = (m_val[c] & ~msk) | (nv & msk);
                if (set) m_raw[c] = 1'b1; else if (wa) m_raw[c] = 1'b0;
                if (wl) begin m_load[c] = pwdata; m_val[c] = pwdata; end
                if (wb) m_load[c] = pwdata;
                if (wc) m_ctrl[c] = pwdata[7:0] & 8'hEF;
            end
            if (psel && penable && pwrite && paddr[11:2] == 10'h3C0) m_ten = pwdata[0];
            if (psel && penable && pwrite && paddr[11:2] == 10'h3C1) m_tout = pwdata[1:0];
            m_irq = nx_irq;
            m_any = |nx_irq;
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [11:0] a);
        if (a >= 12'hFD0) return "R10";
        if (a[11:2] == 10'h3C0) return "R8";
        if (a < 12'h040) begin
            case (a[4:2])
                3'd1:       return "R3";
                3'd4, 3'd5: return "R6";
                3'd0, 3'd2, 3'd6: return "R1";
                default:    return "R11";
            endcase
        end
        return "R11";
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            check(m_ten ? "R8 line" : "R7 line", {30'h0, irq_ch}, {30'h0, m_irq});
            check("R9 combined", {31'h0, irq_any}, {31'h0, m_any});
            check("R13 ready/err", {30'h0, pready, pslverr}, 32'h2);
            if (psel && penable && !pwrite) check(tag_of(paddr), prdata, m_rd);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #2; psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(posedge clk); #2; penable = 1;
        @(posedge clk); #2; psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(posedge clk); #2; psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(posedge clk); #2; penable = 1;
        @(negedge clk); d = prdata;
        @(posedge clk); #2; psel = 0; penable = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    logic [31:0] d;
    bit done = 0;

    task automatic run_all();
        // R12: reset values
        rd(12'h008, d); check("R12 ctrl0", d, 32'h20);
        rd(12'h004, d); check("R12 count0", d, 32'hFFFF_FFFF);
        rd(12'h000, d); check("R12 reload0", d, 32'h0);
        rd(12'h028, d); check("R12 ctrl1", d, 32'h20);
        rd(12'h030, d); check("R12 raw1", d, 32'h0);
        rd(12'hF00, d); check("R12 test_en", d, 32'h0);
        check("R12 lines", {29'h0, irq_any, irq_ch}, 32'h0);

        // R10: identification words, and a write there is ignored
        for (int i = 0; i < 12; i++) begin
            rd(12'hFD0 + 12'(4 * i), d); check("R10 id", d, {24'h0, id_tab[i]});
        end
        wr(12'hFD0, 32'h55);
        rd(12'hFD0, d); check("R10 id write ignored", d, 32'h04);

        // R11: unmapped space
        wr(12'h040, 32'hFF); wr(12'h048, 32'hFF); wr(12'hF08, 32'h1);
        rd(12'h008, d); check("R11 alias write kept out", d, 32'h20);
        rd(12'h040, d); check("R11 unmapped", d, 32'h0);
        rd(12'h01C, d); check("R11 hole", d, 32'h0);
        rd(12'h00C, d); check("R11 ack reads zero", d, 32'h0);
        rd(12'hF08, d); check("R11 test hole", d, 32'h0);

        // R1/R3: periodic 32-bit on channel 0
        wr(12'h000, 32'd5);
        rd(12'h004, d); check("R1 reload copies to count", d, 32'd5);
        wr(12'h008, 32'hE2);
        rd(12'h008, d); check("R1 ctrl readback", d, 32'hE2);
        idle(20);
        rd(12'h010, d); check("R6 raw", d, 32'h1);
        rd(12'h014, d); check("R6 masked", d, 32'h1);
        wr(12'h00C, 32'h0);
        idle(3);
        wr(12'h008, 32'hC2);       // keep running, enable off
        idle(10);
        rd(12'h010, d); check("R6 raw unmasked", d, 32'h1);
        rd(12'h014, d); check("R6 masked off", d, 32'h0);
        wr(12'h008, 32'h00);
        wr(12'h00C, 32'h0);
        rd(12'h010, d); check("R6 ack", d, 32'h0);

        // R2: background reload
        rd(12'h004, d);
        wr(12'h018, 32'h1234);
        rd(12'h000, d); check("R2 reload via 0x00", d, 32'h1234);
        rd(12'h018, d); check("R2 reload via 0x18", d, 32'h1234);

        // R4/R3: 16-bit single-shot, then free-running wrap
        wr(12'h020, 32'h0007_0003);
        wr(12'h028, 32'hA1);
        idle(12);
        rd(12'h024, d); check("R3 single-shot parked", d, 32'h0007_0000);
        wr(12'h028, 32'hA0);
        idle(3);
        rd(12'h024, d); check("R4 upper half held", {16'h0, d[31:16]}, 32'h7);
        wr(12'h028, 32'h00);
        wr(12'h02C, 32'h0);

        // R5: divide by 16, then by 256
        wr(12'h020, 32'd2);
        wr(12'h028, 32'hE6);
        idle(6);
        rd(12'h024, d); check("R5 div16 not yet", d, 32'd2);
        idle(40);
        rd(12'h030, d); check("R5 div16 expired", d, 32'h1);
        wr(12'h020, 32'd1);
        wr(12'h028, 32'hEA);
        wr(12'h02C, 32'h0);
        idle(100);
        rd(12'h030, d); check("R5 div256 not yet", d, 32'h0);
        idle(200);
        rd(12'h030, d); check("R5 div256 expired", d, 32'h1);
        wr(12'h028, 32'h20);

        // R8/R9: test mode overrides the pending channel 1 flag
        wr(12'hF04, 32'h3);
        wr(12'hF00, 32'h1);
        idle(2); #3;
        check("R8 override 11", {30'h0, irq_ch}, 32'h3);
        check("R9 any", {31'h0, irq_any}, 32'h1);
        wr(12'hF04, 32'h0);
        idle(2); #3;
        check("R8 override 00", {30'h0, irq_ch}, 32'h0);
        check("R9 any low", {31'h0, irq_any}, 32'h0);
        rd(12'hF00, d); check("R8 test_en readback", d, 32'h1);
        rd(12'hF04, d); check("R8 test_out write-only", d, 32'h0);
        wr(12'hF00, 32'h0);
        idle(2); #3;
        check("R7 line returns", {30'h0, irq_ch}, 32'h2);
        idle(3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        fork
            begin run_all(); done = 1; end
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    total++; bad++;
                    $display("FAIL watchdog: actual=hung expected=finished");
                end
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule